// File: doc/BRIEF.md
# UART Request Generator

This block turns the state of a UART's receive and transmit buffers into service requests for the host. It watches the buffer occupancy, the push and pop strobes of the receive buffer, the holding-register flags and the per-character error flags. From these it derives three requests: receive, transmit and error. The receive and transmit requests each go to an interrupt line, to a DMA request line, or nowhere, as set by a two-bit mode field per direction. The error request always goes to an interrupt line, which is gated by an enable bit.

There are two operating styles. In FIFO mode, the receive request is driven by a programmable trigger level. A receive time-out also raises it when a partly filled buffer sits idle for three character times, measured in 16x baud ticks. The transmit request is active while the transmit buffer holds no more than its trigger level. In single-register mode, the requests follow the receive holding register being full and the transmit holding register being empty. Error causes are collected in a four-bit status register that is cleared when read.

Top module: `uart_req_gen`

## Requirements
- R1: In FIFO mode the receive request is active one cycle after `rx_count_i` is at or above the receive trigger; a trigger value of 0 counts as 1.
- R2: In FIFO mode, with `rx_count_i` nonzero and below the trigger, the receive request is raised once `baud_tick_i` has pulsed 3 x 16 x (7 + `word_len_i`) times with no push or pop. A character is start bit + 5..8 data bits + stop bit.
- R3: The time-out count restarts on each receive push and each receive pop. It is cleared, and the time-out request with it, while the receive buffer is empty.
- R4: In FIFO mode the transmit request is active one cycle after `tx_count_i` is at or below `tx_trig_i`, and it stays active for as long as that holds.
- R5: With `fifo_en_i` low, the receive request follows `rx_hold_full_i` and the transmit request follows `tx_hold_empty_i`, each with one cycle of delay.
- R6: Mode encoding per direction: 1 sends the request to the `_irq_o` line, 2 sends it to the `_dma_o` line, and 0 or 3 drive neither line.
- R7: `err_stat_o` bit 3 is overrun, bit 2 is parity, bit 1 is frame and bit 0 is break. Flags are taken only with `rx_push_i`, and a set bit stays set until the status is read.
- R8: Overrun is flagged by a push while the receive buffer is full: `rx_count_i` equals DEPTH in FIFO mode, or `rx_hold_full_i` is high in single-register mode.
- R9: A push that carries any error gives exactly one cycle of `err_irq_o`, however many flags it carries, and only when `err_irq_en_i` is 1. The status bits are recorded regardless of the enable.
- R10: `stat_rd_i` clears every status bit in the next cycle, except the bits raised by an error pushed in that same cycle.
- R11: During reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fifo_en_i | input | 1 | 1 = FIFO mode, 0 = single-register mode |
| rx_mode_i | input | 2 | Receive request routing |
| tx_mode_i | input | 2 | Transmit request routing |
| rx_trig_i | input | CW | Receive trigger level |
| tx_trig_i | input | CW | Transmit trigger level |
| word_len_i | input | 2 | Data bits minus 5 |
| err_irq_en_i | input | 1 | Error interrupt enable |
| baud_tick_i | input | 1 | 16x baud-rate tick |
| rx_count_i | input | CW | Receive buffer occupancy |
| tx_count_i | input | CW | Transmit buffer occupancy |
| rx_push_i | input | 1 | A character enters the receive buffer |
| rx_pop_i | input | 1 | Host reads the receive buffer |
| rx_hold_full_i | input | 1 | Receive holding register full |
| tx_hold_empty_i | input | 1 | Transmit holding register empty |
| err_parity_i | input | 1 | Parity error on pushed character |
| err_frame_i | input | 1 | Frame error on pushed character |
| err_break_i | input | 1 | Break on pushed character |
| stat_rd_i | input | 1 | Error status read strobe |
| rx_irq_o | output | 1 | Receive interrupt |
| rx_dma_o | output | 1 | Receive DMA request |
| tx_irq_o | output | 1 | Transmit interrupt |
| tx_dma_o | output | 1 | Transmit DMA request |
| err_irq_o | output | 1 | Error interrupt pulse |
| err_stat_o | output | 4 | Error status, read-to-clear |

## Verification
The hardest case to reach from the ports is the receive time-out. It needs a partial buffer to stay untouched for hundreds of baud ticks, and the request must appear on exactly the tick that ends the third character time. The stimulus holds the count between zero and the trigger and pulses the tick every cycle, and a scoreboard compares every single cycle up to and past the boundary. A pop partway through the wait shows that the count restarts. A second run with the longest word length shows that the limit scales.

// File: rtl/uart_req_pkg.sv
package uart_req_pkg;

  typedef enum logic [1:0] {
    REQ_NONE  = 2'd0,
    REQ_IRQ   = 2'd1,
    REQ_DMA   = 2'd2,
    REQ_NONE3 = 2'd3
  } req_mode_e;

  localparam int ERR_OVR = 3;
  localparam int ERR_PAR = 2;
  localparam int ERR_FRM = 1;
  localparam int ERR_BRK = 0;
  localparam int ERR_W   = 4;

  localparam int FRAME_OVERHEAD = 7;

endpackage

// File: rtl/uart_req_route.sv
module uart_req_route
  import uart_req_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic [1:0] mode_i,
  output logic       irq_o,
  output logic       dma_o
);

  req_mode_e mode;
  logic      irq_d, irq_q;
  logic      dma_d, dma_q;

  assign mode = req_mode_e'(mode_i);

  always_comb begin
    irq_d = req_i && (mode == REQ_IRQ);
    dma_d = req_i && (mode == REQ_DMA);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      dma_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      dma_q <= dma_d;
    end
  end

  assign irq_o = irq_q;
  assign dma_o = dma_q;

  AST_ROUTE_SILENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd0 || mode_i == 2'd3) |=> (!irq_o && !dma_o)); // R6
  AST_ROUTE_DMA_ONLY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == 2'd2) |=> !irq_o); // R6

endmodule

// File: rtl/uart_rx_timeout.sv
module uart_rx_timeout
  import uart_req_pkg::*;
#(
  parameter int CW    = 5,
  parameter int OSR   = 16,
  parameter int CHARS = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fifo_en_i,
  input  logic          baud_tick_i,
  input  logic [1:0]    word_len_i,
  input  logic [CW-1:0] count_i,
  input  logic [CW-1:0] trig_i,
  input  logic          push_i,
  input  logic          pop_i,
  output logic          to_next_o,
  output logic          to_o
);

  localparam int MAX_TICKS = CHARS * OSR * (FRAME_OVERHEAD + 3);
  localparam int TW        = $clog2(MAX_TICKS + 1);

  logic [TW-1:0] cnt_d, cnt_q;
  logic          to_d, to_q;
  logic [TW-1:0] lim_m1;
  logic          restart;
  logic          cnt_en;

  always_comb begin
    lim_m1  = TW'(CHARS * OSR * (FRAME_OVERHEAD + int'(word_len_i)) - 1);
    restart = !fifo_en_i || push_i || pop_i || (count_i == '0) || (count_i >= trig_i);
    cnt_en  = baud_tick_i && !to_q;
  end

  always_comb begin
    cnt_d = cnt_q;
    to_d  = to_q;
    if (restart) begin
      cnt_d = '0;
      to_d  = 1'b0;
    end else if (cnt_en) begin
      if (cnt_q == lim_m1) begin
        cnt_d = '0;
        to_d  = 1'b1;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      to_q  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      to_q  <= to_d;
    end
  end

  assign to_next_o = to_d;
  assign to_o      = to_q;

  AST_TO_NEEDS_DATA: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(to_o) |-> ($past(count_i) != '0)); // R2
  AST_TO_PUSH_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i || pop_i) |=> !to_o); // R3
  AST_TO_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= TW'(MAX_TICKS)); // R2

endmodule

// File: rtl/uart_err_status.sv
module uart_err_status
  import uart_req_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic             full_i,
  input  logic             parity_i,
  input  logic             frame_i,
  input  logic             break_i,
  input  logic             rd_i,
  input  logic             en_i,
  output logic [ERR_W-1:0] stat_o,
  output logic             irq_o
);

  logic [ERR_W-1:0] new_err;
  logic [ERR_W-1:0] stat_d, stat_q;
  logic             irq_d, irq_q;

  always_comb begin
    new_err          = '0;
    new_err[ERR_OVR] = push_i && full_i;
    new_err[ERR_PAR] = push_i && parity_i;
    new_err[ERR_FRM] = push_i && frame_i;
    new_err[ERR_BRK] = push_i && break_i;
  end

  always_comb begin
    stat_d = (rd_i ? '0 : stat_q) | new_err;
    irq_d  = en_i && (|new_err);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= irq_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  AST_RD_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && !push_i) |=> (stat_o == '0)); // R10
  AST_STAT_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_i && !push_i) |=> $stable(stat_o)); // R7
  AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(en_i)); // R9
  AST_IRQ_NEEDS_PUSH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> $past(push_i)); // R9

endmodule

// File: rtl/uart_req_gen.sv
module uart_req_gen
  import uart_req_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1),
  parameter int OSR   = 16,
  parameter int CHARS = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_en_i,
  input  logic [1:0]       rx_mode_i,
  input  logic [1:0]       tx_mode_i,
  input  logic [CW-1:0]    rx_trig_i,
  input  logic [CW-1:0]    tx_trig_i,
  input  logic [1:0]       word_len_i,
  input  logic             err_irq_en_i,
  input  logic             baud_tick_i,
  input  logic [CW-1:0]    rx_count_i,
  input  logic [CW-1:0]    tx_count_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             rx_hold_full_i,
  input  logic             tx_hold_empty_i,
  input  logic             err_parity_i,
  input  logic             err_frame_i,
  input  logic             err_break_i,
  input  logic             stat_rd_i,
  output logic             rx_irq_o,
  output logic             rx_dma_o,
  output logic             tx_irq_o,
  output logic             tx_dma_o,
  output logic             err_irq_o,
  output logic [ERR_W-1:0] err_stat_o
);

  localparam int NDIR   = 2;
  localparam int DIR_RX = 0;
  localparam int DIR_TX = 1;

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rs_q;
  logic       rst_n_s;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rs_q <= 2'b00;
    else         rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_n_s = rs_q[1];

  logic [CW-1:0] rx_trig_eff;
  logic          rx_full;
  logic          rx_level;
  logic          tx_level;
  logic          to_next, to_q;
  logic [NDIR-1:0]      dir_req;
  logic [NDIR-1:0][1:0] dir_mode;
  logic [NDIR-1:0]      dir_irq;
  logic [NDIR-1:0]      dir_dma;

  always_comb begin
    rx_trig_eff = (rx_trig_i == '0) ? CW'(1) : rx_trig_i;
    rx_full     = fifo_en_i ? (rx_count_i == CW'(DEPTH)) : rx_hold_full_i;
    rx_level    = rx_count_i >= rx_trig_eff;
    tx_level    = tx_count_i <= tx_trig_i;
  end

  uart_rx_timeout #(
    .CW    (CW),
    .OSR   (OSR),
    .CHARS (CHARS)
  ) u_timeout (
    .clk_i       (clk_i),
    .rst_ni      (rst_n_s),
    .fifo_en_i   (fifo_en_i),
    .baud_tick_i (baud_tick_i),
    .word_len_i  (word_len_i),
    .count_i     (rx_count_i),
    .trig_i      (rx_trig_eff),
    .push_i      (rx_push_i),
    .pop_i       (rx_pop_i),
    .to_next_o   (to_next),
    .to_o        (to_q)
  );

  always_comb begin
    dir_req[DIR_RX]  = fifo_en_i ? (rx_level || to_next) : rx_hold_full_i;
    dir_req[DIR_TX]  = fifo_en_i ? tx_level : tx_hold_empty_i;
    dir_mode[DIR_RX] = rx_mode_i;
    dir_mode[DIR_TX] = tx_mode_i;
  end

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    uart_req_route u_route (
      .clk_i  (clk_i),
      .rst_ni (rst_n_s),
      .req_i  (dir_req[g]),
      .mode_i (dir_mode[g]),
      .irq_o  (dir_irq[g]),
      .dma_o  (dir_dma[g])
    );
  end

  assign rx_irq_o = dir_irq[DIR_RX];
  assign rx_dma_o = dir_dma[DIR_RX];
  assign tx_irq_o = dir_irq[DIR_TX];
  assign tx_dma_o = dir_dma[DIR_TX];

  uart_err_status u_err (
    .clk_i    (clk_i),
    .rst_ni   (rst_n_s),
    .push_i   (rx_push_i),
    .full_i   (rx_full),
    .parity_i (err_parity_i),
    .frame_i  (err_frame_i),
    .break_i  (err_break_i),
    .rd_i     (stat_rd_i),
    .en_i     (err_irq_en_i),
    .stat_o   (err_stat_o),
    .irq_o    (err_irq_o)
  );

  AST_TX_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (fifo_en_i && tx_mode_i == 2'd1 && tx_count_i <= tx_trig_i) |=> tx_irq_o); // R4
  AST_RX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (!fifo_en_i && rx_mode_i == 2'd2 && !rx_hold_full_i) |=> !rx_dma_o); // R5
  AST_OVR_FIFO: assert property (@(posedge clk_i) disable iff (!rst_n_s)
    (fifo_en_i && rx_push_i && rx_count_i == CW'(DEPTH)) |=> err_stat_o[ERR_OVR]); // R8
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_n_s |-> !(rx_irq_o || rx_dma_o || tx_irq_o || tx_dma_o || err_irq_o)); // R11

endmodule

// File: tb/sim_uart_req_gen.sv
`timescale 1ns/1ps
module sim_uart_req_gen;

  localparam int DEPTH = 16;
  localparam int CW    = 5;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          fifo_en;
  logic [1:0]    rx_mode, tx_mode, wl;
  logic [CW-1:0] rx_trig, tx_trig, rx_count, tx_count;
  logic          err_en, tick, push, pop, hfull, hempty, par, frm, brk, rd;
  logic          rx_irq, rx_dma, tx_irq, tx_dma, err_irq;
  logic [3:0]    err_stat;

  uart_req_gen #(.DEPTH(DEPTH)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .fifo_en_i(fifo_en), .rx_mode_i(rx_mode),
    .tx_mode_i(tx_mode), .rx_trig_i(rx_trig), .tx_trig_i(tx_trig),
    .word_len_i(wl), .err_irq_en_i(err_en), .baud_tick_i(tick),
    .rx_count_i(rx_count), .tx_count_i(tx_count), .rx_push_i(push),
    .rx_pop_i(pop), .rx_hold_full_i(hfull), .tx_hold_empty_i(hempty),
    .err_parity_i(par), .err_frame_i(frm), .err_break_i(brk),
    .stat_rd_i(rd), .rx_irq_o(rx_irq), .rx_dma_o(rx_dma), .tx_irq_o(tx_irq),
    .tx_dma_o(tx_dma), .err_irq_o(err_irq), .err_stat_o(err_stat)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [8:0] qv[$];
  string      qt[$];

  // reference model state, built from the requirements
  logic [3:0] m_stat = 4'd0;
  int         m_cnt  = 0;
  bit         m_to   = 1'b0;

  task automatic predict(output logic [8:0] e);
    logic [3:0] ne;
    logic       full_m, rxr, txr;
    int         trig_e, lim;
    full_m = fifo_en ? (rx_count == CW'(DEPTH)) : hfull;
    ne     = {push & full_m, push & par, push & frm, push & brk};
    m_stat = (rd ? 4'd0 : m_stat) | ne;
    trig_e = (rx_trig == 0) ? 1 : int'(rx_trig);
    lim    = 3 * 16 * (7 + int'(wl));
    if (!fifo_en || push || pop || rx_count == 0 || int'(rx_count) >= trig_e) begin
      m_cnt = 0; m_to = 1'b0;
    end else if (tick && !m_to) begin
      if (m_cnt == lim - 1) begin m_to = 1'b1; m_cnt = 0; end
      else m_cnt++;
    end
    rxr = fifo_en ? (int'(rx_count) >= trig_e || m_to) : hfull;
    txr = fifo_en ? (tx_count <= tx_trig) : hempty;
    e = {rxr && rx_mode == 2'd1, rxr && rx_mode == 2'd2,
         txr && tx_mode == 2'd1, txr && tx_mode == 2'd2,
         err_en && (|ne), m_stat};
  endtask

  task automatic step(input string tag);
    logic [8:0] e;
    predict(e);
    qv.push_back(e);
    qt.push_back(tag);
    @(negedge clk);
  endtask

  // monitor: compares design results against the queued expectations
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (qv.size() > 0) begin
        logic [8:0] exp_v, act_v;
        string      t;
        exp_v = qv.pop_front();
        t     = qt.pop_front();
        act_v = {rx_irq, rx_dma, tx_irq, tx_dma, err_irq, err_stat};
        checks++;
        if (act_v !== exp_v) begin
          errors++;
          $display("FAIL %s actual %b expected %b", t, act_v, exp_v);
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual running expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; fifo_en = 1'b1; rx_mode = 2'd1; tx_mode = 2'd1; wl = 2'd0;
    rx_trig = 5'd8; tx_trig = 5'd2; rx_count = '0; tx_count = 5'd10;
    err_en = 1'b1; tick = 1'b0; push = 1'b0; pop = 1'b0; hfull = 1'b0;
    hempty = 1'b0; par = 1'b0; frm = 1'b0; brk = 1'b0; rd = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if ({rx_irq, rx_dma, tx_irq, tx_dma, err_irq, err_stat} !== 9'd0) begin
      errors++;
      $display("FAIL R11 actual %b expected %b",
               {rx_irq, rx_dma, tx_irq, tx_dma, err_irq, err_stat}, 9'd0);
    end
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    step("R11 idle after reset");
    rx_count = 5'd7; step("R1 below trigger");
    rx_count = 5'd8; step("R1 at trigger");
    rx_trig = 5'd0; rx_count = 5'd1; step("R1 trigger zero acts as one");
    rx_mode = 2'd2; step("R6 rx to dma");
    rx_mode = 2'd0; step("R6 rx mode 0 silent");
    rx_mode = 2'd3; step("R6 rx mode 3 silent");
    rx_mode = 2'd1; rx_trig = 5'd8; rx_count = 5'd0; step("R1 empty quiet");

    tx_count = 5'd2; step("R4 tx at trigger");
    tx_count = 5'd0; step("R4 tx below trigger");
    tx_count = 5'd3; step("R4 tx above trigger");
    tx_mode = 2'd2; tx_count = 5'd1; step("R6 tx to dma");
    tx_mode = 2'd0; step("R6 tx mode 0 silent");
    tx_mode = 2'd1; tx_count = 5'd10; step("R4 tx quiet again");

    fifo_en = 1'b0; hfull = 1'b1; step("R5 rx holding full");
    hfull = 1'b0; hempty = 1'b1; step("R5 tx holding empty");
    rx_mode = 2'd2; hfull = 1'b1; step("R5 rx holding to dma");
    rx_mode = 2'd1; hempty = 1'b0;
    push = 1'b1; par = 1'b1; frm = 1'b1; step("R8 R9 single-reg overrun with parity frame");
    push = 1'b0; par = 1'b0; frm = 1'b0; step("R9 single pulse");
    step("R7 status sticky");
    rd = 1'b1; step("R10 read clears");
    rd = 1'b0; hfull = 1'b0; fifo_en = 1'b1; step("R10 cleared stays");

    rx_count = 5'd16; push = 1'b1; step("R8 fifo overrun");
    push = 1'b0; rx_count = 5'd3; step("R7 overrun held");
    rd = 1'b1; push = 1'b1; par = 1'b1; step("R10 read with new parity");
    rd = 1'b0; push = 1'b0; par = 1'b0; step("R10 new error kept");
    err_en = 1'b0; push = 1'b1; brk = 1'b1; step("R9 disabled error records");
    push = 1'b0; brk = 1'b0; step("R9 no pulse when disabled");
    err_en = 1'b1; rd = 1'b1; step("R10 clear all"); rd = 1'b0;

    // time-out with 5 data bits: 336 ticks
    rx_count = 5'd2; push = 1'b1; step("R3 push restarts");
    push = 1'b0; tick = 1'b1;
    for (int i = 0; i < 200; i++) step("R2 waiting 5-bit");
    pop = 1'b1; rx_count = 5'd1; step("R3 pop restarts");
    pop = 1'b0;
    for (int i = 0; i < 340; i++) step("R2 time-out 5-bit");
    rx_mode = 2'd2; step("R2 time-out to dma");
    rx_mode = 2'd1;
    rx_count = 5'd0; step("R3 empty clears time-out");
    rx_count = 5'd4; step("R3 restarted from empty");
    tick = 1'b0; repeat (5) step("R2 no tick no progress");
    tick = 1'b1; wl = 2'd3;
    for (int i = 0; i < 485; i++) step("R2 time-out 8-bit");
    push = 1'b1; rx_count = 5'd5; step("R3 push clears time-out");
    push = 1'b0; tick = 1'b0; rx_count = 5'd0; step("R3 idle");

    @(posedge clk); #2;
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule